// File: doc/BRIEF.md
# Sample Clock Phase Alignment Controller

This block computes the fine phase-shift code for the phase-adjust DAC of a clock PLL, so that a device's sample clock can be slid against a shared reference until several devices line up. Two edge-offset measurements arrive as unsigned sample-clock counts: one from this device and one from the chosen reference device. The controller subtracts the reference measurement from the local one and scales the difference into fine steps. It then adds a signed manual trim for residual skew. The result is clamped to one sample period either side of zero. A zero code leaves the clock nominally in phase with the reference.

A one-cycle load strobe starts a calculation. A small state machine walks through four named states. ST_IDLE waits for the strobe and, on it, captures the inputs (transition IDLE→SCALE). ST_SCALE forms the scaled sum (SCALE→APPLY). ST_APPLY writes the clamped code and the sticky out-of-range flag (APPLY→REPORT). ST_REPORT arms the done pulse and returns unconditionally (REPORT→IDLE). Strobes that arrive outside ST_IDLE are dropped.

Top module: `phase_align_ctrl`

## Requirements
- R1: Reset forces the phase code to 0 and clears the done pulse and the out-of-range flag.
- R2: In range, the code equals (local − reference) × STEPS_PER_PERIOD + trim. The measurements are unsigned MEAS_W-bit counts. Trim and code are two's-complement CODE_W-bit values.
- R3: The code never leaves −STEPS_PER_PERIOD … +STEPS_PER_PERIOD. A larger result saturates at the nearer limit, and a result exactly at a limit passes unchanged.
- R4: Equal measurements with zero trim give a code of 0.
- R5: Saturation sets the out-of-range flag. The flag stays set through later in-range loads until reset.
- R6: The code changes only as a result of a load. It takes its new value on the second rising edge after the edge that samples the strobe, and it is stable at all other times.
- R7: done_o is high for exactly one cycle, beginning on the rising edge after the code update.
- R8: A load strobe sampled while a calculation is in progress (ST_SCALE, ST_APPLY or ST_REPORT) is ignored, and the result of the running calculation is kept.
- R9: The trim is added even when the measurement difference is zero, and negative trims yield negative codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start strobe, one cycle |
| local_meas_i | input | MEAS_W | This device's edge offset in sample-clock counts |
| ref_meas_i | input | MEAS_W | Reference device's edge offset in sample-clock counts |
| trim_i | input | CODE_W | Signed manual calibration offset in fine steps |
| phase_code_o | output | CODE_W | Signed, saturated phase-adjust code |
| done_o | output | 1 | One-cycle pulse after a code update |
| out_of_range_o | output | 1 | Sticky saturation flag |

## Verification
The arithmetic is tried with equal measurements (zero and non-zero trim), with small positive and negative differences combined with opposing trims, and with differences far beyond one period in both directions. Together these separate a wrong subtraction order, a missing scale, a dropped trim and a wrong clamp direction. An input that lands exactly on the negative limit separates saturation at the limit from saturation only past it. An in-range load after a saturated one shows whether the flag is sticky. A second strobe sent during a running calculation, and input changes made with no strobe, show whether anything other than an accepted load can move the code.

// File: rtl/pac_pkg.sv
package pac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_APPLY  = 2'd2,
        ST_REPORT = 2'd3
    } pac_state_e;
endpackage

// File: rtl/pac_fsm.sv
module pac_fsm
    import pac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic capture_en_o,
    output logic scale_en_o,
    output logic apply_en_o,
    output logic done_o
);
    pac_state_e state_q, state_d;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_i) state_d = ST_SCALE;
            ST_SCALE:  state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_en_o = (state_q == ST_IDLE) && load_i;
        scale_en_o   = (state_q == ST_SCALE);
        apply_en_o   = (state_q == ST_APPLY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_REPORT);
    end
    assign done_o = done_q;

    AST_APPLY_THEN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> (state_q == ST_REPORT)); // R7
    AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCALE) |=> (state_q == ST_APPLY)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
endmodule

// File: rtl/pac_datapath.sv
module pac_datapath #(
    parameter int MEAS_W           = 8,
    parameter int STEPS_PER_PERIOD = 1000,
    parameter int CODE_W           = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture_en_i,
    input  logic                     scale_en_i,
    input  logic                     apply_en_i,
    input  logic [MEAS_W-1:0]        local_meas_i,
    input  logic [MEAS_W-1:0]        ref_meas_i,
    input  logic signed [CODE_W-1:0] trim_i,
    output logic signed [CODE_W-1:0] code_o,
    output logic                     oor_o
);
    localparam int SUM_W = MEAS_W + CODE_W + 2;
    localparam logic signed [SUM_W-1:0]  LIM_P    = SUM_W'(STEPS_PER_PERIOD);
    localparam logic signed [SUM_W-1:0]  LIM_N    = -LIM_P;
    localparam logic signed [CODE_W-1:0] CODE_MAX = CODE_W'(STEPS_PER_PERIOD);
    localparam logic signed [CODE_W-1:0] CODE_MIN = -CODE_MAX;

    logic signed [MEAS_W:0]   diff_d, diff_q;
    logic signed [CODE_W-1:0] trim_q;
    logic signed [SUM_W-1:0]  diff_ext, trim_ext, sum_d, sum_q;
    logic signed [CODE_W-1:0] code_d, code_q;
    logic                     sat_d, oor_q;

    assign diff_d = $signed({1'b0, local_meas_i}) - $signed({1'b0, ref_meas_i});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            trim_q <= '0;
        end else if (capture_en_i) begin
            diff_q <= diff_d;
            trim_q <= trim_i;
        end
    end

    assign diff_ext = {{(SUM_W-MEAS_W-1){diff_q[MEAS_W]}}, diff_q};
    assign trim_ext = {{(SUM_W-CODE_W){trim_q[CODE_W-1]}}, trim_q};
    assign sum_d    = diff_ext * LIM_P + trim_ext;

    always_ff @(posedge clk) begin
        if (!rst_n)          sum_q <= '0;
        else if (scale_en_i) sum_q <= sum_d;
    end

    always_comb begin
        if (sum_q > LIM_P) begin
            code_d = CODE_MAX;
            sat_d  = 1'b1;
        end else if (sum_q < LIM_N) begin
            code_d = CODE_MIN;
            sat_d  = 1'b1;
        end else begin
            code_d = sum_q[CODE_W-1:0];
            sat_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            oor_q  <= 1'b0;
        end else if (apply_en_i) begin
            code_q <= code_d;
            oor_q  <= oor_q | sat_d;
        end
    end

    assign code_o = code_q;
    assign oor_o  = oor_q;

    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q <= CODE_MAX) && (code_q >= CODE_MIN)); // R3
    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_en_i |=> $stable(code_q)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        oor_q |=> oor_q); // R5
    AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oor_q) |-> ((code_q == CODE_MAX) || (code_q == CODE_MIN))); // R5
endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl #(
    parameter int MEAS_W           = 8,
    parameter int STEPS_PER_PERIOD = 1000,
    parameter int CODE_W           = $clog2(STEPS_PER_PERIOD + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [MEAS_W-1:0]        local_meas_i,
    input  logic [MEAS_W-1:0]        ref_meas_i,
    input  logic signed [CODE_W-1:0] trim_i,
    output logic signed [CODE_W-1:0] phase_code_o,
    output logic                     done_o,
    output logic                     out_of_range_o
);
    logic capture_en, scale_en, apply_en;

    pac_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .capture_en_o (capture_en),
        .scale_en_o   (scale_en),
        .apply_en_o   (apply_en),
        .done_o       (done_o)
    );

    pac_datapath #(
        .MEAS_W           (MEAS_W),
        .STEPS_PER_PERIOD (STEPS_PER_PERIOD),
        .CODE_W           (CODE_W)
    ) i_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_en_i (capture_en),
        .scale_en_i   (scale_en),
        .apply_en_i   (apply_en),
        .local_meas_i (local_meas_i),
        .ref_meas_i   (ref_meas_i),
        .trim_i       (trim_i),
        .code_o       (phase_code_o),
        .oor_o        (out_of_range_o)
    );

    AST_DONE_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $stable(phase_code_o)); // R7
endmodule

// File: tb/test_phase_align_ctrl.sv
module test_phase_align_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEAS_W     = 8;
    localparam int STEPS      = 1000;
    localparam int CODE_W     = $clog2(STEPS + 1) + 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     load_i = 1'b0;
    logic [MEAS_W-1:0]        local_meas_i = '0;
    logic [MEAS_W-1:0]        ref_meas_i = '0;
    logic signed [CODE_W-1:0] trim_i = '0;
    logic signed [CODE_W-1:0] phase_code_o;
    logic                     done_o;
    logic                     out_of_range_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_align_ctrl #(.MEAS_W(MEAS_W), .STEPS_PER_PERIOD(STEPS)) i_phase_align_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load_i),
        .local_meas_i   (local_meas_i),
        .ref_meas_i     (ref_meas_i),
        .trim_i         (trim_i),
        .phase_code_o   (phase_code_o),
        .done_o         (done_o),
        .out_of_range_o (out_of_range_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One accepted load with full timing check (R6, R7)
    task automatic run_load(input int loc, input int rf, input int trim,
                            input int exp_code, input int exp_oor, input string req);
        @(negedge clk);
        local_meas_i = MEAS_W'(loc);
        ref_meas_i   = MEAS_W'(rf);
        trim_i       = CODE_W'(trim);
        load_i       = 1'b1;
        @(negedge clk);                 // after edge k
        load_i = 1'b0;
        @(negedge clk);                 // after edge k+1
        @(negedge clk);                 // after edge k+2: code updated
        check({req, " code"}, int'(phase_code_o), exp_code);
        check({req, " oor"}, int'(out_of_range_o), exp_oor);
        check("R7 done low at update", int'(done_o), 0);
        @(negedge clk);                 // after edge k+3
        check("R7 done pulse", int'(done_o), 1);
        @(negedge clk);                 // after edge k+4
        check("R7 done single cycle", int'(done_o), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 code", int'(phase_code_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 oor", int'(out_of_range_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_busy_load();
        @(negedge clk);
        local_meas_i = 8'd9; ref_meas_i = 8'd9; trim_i = CODE_W'(100);
        load_i = 1'b1;
        @(negedge clk);                 // after edge k, now in ST_SCALE
        local_meas_i = 8'd20; ref_meas_i = 8'd9; trim_i = CODE_W'(-5);
        @(negedge clk);                 // after edge k+1, strobe ignored
        load_i = 1'b0;
        @(negedge clk);                 // after edge k+2
        check("R8 busy strobe ignored", int'(phase_code_o), 100);
        repeat (6) @(negedge clk);
        check("R8 no late second result", int'(phase_code_o), 100);
    endtask

    task automatic test_hold();
        @(negedge clk);
        local_meas_i = 8'd200; ref_meas_i = 8'd3; trim_i = CODE_W'(-300);
        repeat (8) @(negedge clk);
        check("R6 code holds without load", int'(phase_code_o), 100);
        check("R6 no done without load", int'(done_o), 0);
    endtask

    initial begin
        test_reset();
        run_load(5, 5, 0, 0, 0, "R4 zero diff");
        run_load(5, 5, 37, 37, 0, "R9 trim only");
        run_load(5, 5, -40, -40, 0, "R9 negative trim");
        run_load(6, 5, -250, 750, 0, "R2 diff plus trim");
        run_load(5, 6, 0, -1000, 0, "R3 exact negative limit");
        run_load(4, 5, 999, -1, 0, "R2 negative diff");
        run_load(7, 5, 0, 1000, 1, "R3 R5 positive saturation");
        run_load(5, 5, 12, 12, 1, "R5 flag sticky");
        run_load(0, 200, 0, -1000, 1, "R3 negative saturation");
        test_busy_load();
        test_hold();
        test_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule